// File: doc/BRIEF.md
# VID-Programmed Power-Good Monitor

This block watches the core rail of a buck regulator whose target voltage is chosen by a 5-bit voltage-identification code. On every sample strobe it converts the code into a setpoint in millivolts and compares a digitized core voltage against a window around that setpoint. The window has hysteresis, and a separate comparison flags an overvoltage. It also runs an undervoltage check with hysteresis on each of three linear rails. The combined verdict is one active-high power-good flag. The overvoltage flag is meant for a downstream fault sequencer.

An upstream converter delivers millivolt codes together with a one-cycle valid strobe. Every threshold is a percentage of a target. The block never divides. It compares `v*100` against `target*pct`, so each decision is exact in integer arithmetic. A code change restarts the core hysteresis and masks power-good for a fixed number of samples, so the rail has time to settle.

Top module: `vid_pgood_mon`

## Requirements
- R1: With code bit 4 = 0, the setpoint is 1300 + 50*(15 - code[3:0]) mV, covering 1300 mV (code 01111) to 2050 mV (code 00000).
- R2: With code bit 4 = 1, the setpoint is 2000 + 100*(15 - code[3:0]) mV. Code 11111 gives 2000 mV and code 10000 gives 3500 mV.
- R3: Low side of the core window. A core rail that is in window falls out when `v*100 < sp*92`. A core rail that is out of window can return only when `v*100 >= sp*94`. Between these two thresholds the previous state holds.
- R4: High side of the core window. A core rail that is in window falls out when `v*100 > sp*110`. Return needs `v*100 <= sp*108`, and the low-side return condition must also hold. Between these two thresholds the previous state holds.
- R5: `ov_o` is 1 after a sample with `v*100 > sp*115` (strictly greater), and 0 after any other sample.
- R6: Each linear rail has a target: 1500, 1500 and 1800 mV for index 0, 1 and 2. A rail that is good goes bad when `l*100 < tgt*75`. A rail that is bad becomes good only when `l*100 >= tgt*82`. Between these two thresholds the previous state holds.
- R7: After a sample with code 11111, `pgood_o` is 1 no matter what any voltage is.
- R8: A sample whose code differs from the previously sampled code clears the core in-window state. That sample and the next BLANK_SAMPLES samples (default 4) give `pgood_o` = 0, except under R7.
- R9: Reset sets `pgood_o` = 0, `ov_o` = 0 and `setpoint_mv_o` = 0. The stored code becomes 00000 and the core and linear states become not-good. The first BLANK_SAMPLES samples after reset give `pgood_o` = 0 (except under R7).
- R10: The outputs change only at a clock edge where `sample_valid_i` is 1. They take their new value at that edge and hold it until the next strobe.
- R11: Outside R7 and the blanking of R8/R9, `pgood_o` is the AND of the updated core in-window state and all three updated linear good states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_valid_i | input | 1 | One-cycle strobe marking a new sample |
| vid_i | input | 5 | Voltage-identification code |
| vcore_mv_i | input | MV_W (13) | Core rail sample in mV |
| lin_mv_i | input | N_LIN*MV_W (39) | Linear rail samples in mV, index 0 in the low bits |
| setpoint_mv_o | output | MV_W (13) | Decoded setpoint in mV |
| pgood_o | output | 1 | Power good, active high |
| ov_o | output | 1 | Core overvoltage |

## Verification
Two things can happen in the same sample: a code change that clears the core state and starts blanking, and a core voltage that crosses a window or overvoltage threshold. The bench provokes this by sweeping all 32 codes back to back, with each code's run starting at a voltage far from the new setpoint. It then checks that power-good stays low while blanking is active and that `ov_o` still follows the new setpoint in that same sample. The all-ones code lands on top of blanking as well. An arithmetic model in the bench decides the expected flag for every sample, including the samples in the hysteresis bands on both sides of the window.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  localparam logic [4:0]  VID_FORCE_GOOD = 5'h1F;
  localparam int unsigned LO_BASE_MV  = 1300;
  localparam int unsigned LO_STEP_MV  = 50;
  localparam int unsigned HI_BASE_MV  = 2000;
  localparam int unsigned HI_STEP_MV  = 100;
  localparam int unsigned PCT_FULL    = 100;
  localparam int unsigned PCT_LO_TRIP = 92;
  localparam int unsigned PCT_LO_REL  = 94;
  localparam int unsigned PCT_HI_TRIP = 110;
  localparam int unsigned PCT_HI_REL  = 108;
  localparam int unsigned PCT_OV      = 115;
  localparam int unsigned PCT_UV_TRIP = 75;
  localparam int unsigned PCT_UV_REL  = 82;
  localparam int unsigned PCT_W       = 7;
endpackage

// File: rtl/vpg_vid_decode.sv
module vpg_vid_decode
  import vpg_pkg::*;
#(
  parameter int unsigned MV_W = 13
) (
  input  logic [4:0]      vid_i,
  output logic [MV_W-1:0] sp_mv_o
);
  logic [3:0] step;
  assign step = ~vid_i[3:0];

  always_comb begin
    if (vid_i[4]) sp_mv_o = MV_W'(HI_BASE_MV) + MV_W'(HI_STEP_MV) * MV_W'(step);
    else          sp_mv_o = MV_W'(LO_BASE_MV) + MV_W'(LO_STEP_MV) * MV_W'(step);
  end

  always_comb begin
    assert_sp_range_R1: assert (sp_mv_o >= MV_W'(LO_BASE_MV) &&
                                sp_mv_o <= MV_W'(HI_BASE_MV + 15*HI_STEP_MV));
  end
endmodule

// File: rtl/vpg_core_window.sv
module vpg_core_window
  import vpg_pkg::*;
#(
  parameter int unsigned MV_W = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            clr_i,
  input  logic [MV_W-1:0] sp_mv_i,
  input  logic [MV_W-1:0] vcore_mv_i,
  output logic            ok_d_o,
  output logic            ov_d_o
);
  localparam int unsigned PW = MV_W + PCT_W;

  logic [PW-1:0] v_s, lo_trip, lo_rel, hi_trip, hi_rel, ov_thr;
  logic          ok_q, trip, rel;

  assign v_s     = PW'(vcore_mv_i) * PW'(PCT_FULL);
  assign lo_trip = PW'(sp_mv_i) * PW'(PCT_LO_TRIP);
  assign lo_rel  = PW'(sp_mv_i) * PW'(PCT_LO_REL);
  assign hi_trip = PW'(sp_mv_i) * PW'(PCT_HI_TRIP);
  assign hi_rel  = PW'(sp_mv_i) * PW'(PCT_HI_REL);
  assign ov_thr  = PW'(sp_mv_i) * PW'(PCT_OV);

  assign trip   = (v_s < lo_trip) || (v_s > hi_trip);
  assign rel    = (v_s >= lo_rel) && (v_s <= hi_rel);
  assign ov_d_o = v_s > ov_thr;

  always_comb begin
    ok_d_o = ok_q;
    if (clr_i)             ok_d_o = 1'b0;
    else if (valid_i) begin
      if (ok_q && trip)    ok_d_o = 1'b0;
      else if (!ok_q && rel) ok_d_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= ok_d_o;
  end

  assert_lo_trip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && v_s < lo_trip) |=> !ok_q);
  assert_hi_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && v_s > hi_trip) |=> !ok_q);
  assert_hold_band_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i && !ok_q && v_s < lo_rel) |=> !ok_q);
  assert_code_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ok_q);
endmodule

// File: rtl/vpg_lin_uv.sv
module vpg_lin_uv
  import vpg_pkg::*;
#(
  parameter int unsigned      MV_W   = 13,
  parameter logic [MV_W-1:0]  TGT_MV = 1500
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [MV_W-1:0] lin_mv_i,
  output logic            ok_d_o
);
  localparam int unsigned     PW       = MV_W + PCT_W;
  localparam logic [PW-1:0]   TRIP_THR = PW'(TGT_MV) * PW'(PCT_UV_TRIP);
  localparam logic [PW-1:0]   REL_THR  = PW'(TGT_MV) * PW'(PCT_UV_REL);

  logic [PW-1:0] l_s;
  logic          ok_q;

  assign l_s = PW'(lin_mv_i) * PW'(PCT_FULL);

  always_comb begin
    ok_d_o = ok_q;
    if (valid_i) begin
      if (ok_q && l_s < TRIP_THR)       ok_d_o = 1'b0;
      else if (!ok_q && l_s >= REL_THR) ok_d_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= ok_d_o;
  end

  assert_uv_trip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && l_s < TRIP_THR) |=> !ok_q);
  assert_uv_rel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && l_s >= REL_THR) |=> ok_q);
endmodule

// File: rtl/vid_pgood_mon.sv
module vid_pgood_mon
  import vpg_pkg::*;
#(
  parameter int unsigned              MV_W          = 13,
  parameter int unsigned              N_LIN         = 3,
  parameter logic [N_LIN*MV_W-1:0]    LIN_TGT_MV    = {13'd1800, 13'd1500, 13'd1500},
  parameter int unsigned              BLANK_SAMPLES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_valid_i,
  input  logic [4:0]              vid_i,
  input  logic [MV_W-1:0]         vcore_mv_i,
  input  logic [N_LIN*MV_W-1:0]   lin_mv_i,
  output logic [MV_W-1:0]         setpoint_mv_o,
  output logic                    pgood_o,
  output logic                    ov_o
);
  localparam int unsigned BW = $clog2(BLANK_SAMPLES + 1);

  logic [4:0]       vid_q;
  logic [BW-1:0]    blank_q;
  logic [MV_W-1:0]  sp_d;
  logic             change, clr, blanked, core_ok_d, ov_d;
  logic [N_LIN-1:0] lin_ok_d;

  assign change  = vid_i != vid_q;
  assign clr     = sample_valid_i && change;
  assign blanked = change || (blank_q != '0);

  vpg_vid_decode #(.MV_W(MV_W)) u_dec (.vid_i(vid_i), .sp_mv_o(sp_d));

  vpg_core_window #(.MV_W(MV_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(sample_valid_i), .clr_i(clr),
    .sp_mv_i(sp_d), .vcore_mv_i(vcore_mv_i), .ok_d_o(core_ok_d), .ov_d_o(ov_d)
  );

  for (genvar g = 0; g < N_LIN; g++) begin : g_lin
    vpg_lin_uv #(.MV_W(MV_W), .TGT_MV(LIN_TGT_MV[g*MV_W +: MV_W])) u_uv (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(sample_valid_i),
      .lin_mv_i(lin_mv_i[g*MV_W +: MV_W]), .ok_d_o(lin_ok_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_q         <= '0;
      blank_q       <= BW'(BLANK_SAMPLES);
      setpoint_mv_o <= '0;
      pgood_o       <= 1'b0;
      ov_o          <= 1'b0;
    end else if (sample_valid_i) begin
      vid_q         <= vid_i;
      setpoint_mv_o <= sp_d;
      ov_o          <= ov_d;
      pgood_o       <= (vid_i == VID_FORCE_GOOD) ||
                       (!blanked && core_ok_d && (&lin_ok_d));
      if (change)              blank_q <= BW'(BLANK_SAMPLES);
      else if (blank_q != '0)  blank_q <= blank_q - 1'b1;
    end
  end

  assert_force_good_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && vid_i == VID_FORCE_GOOD) |=> pgood_o);
  assert_blank_on_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && change && vid_i != VID_FORCE_GOOD) |=> !pgood_o);
  assert_ov_excludes_good_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_o && vid_q != VID_FORCE_GOOD) |-> !pgood_o);
  assert_hold_between_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> ($stable(pgood_o) && $stable(ov_o) && $stable(setpoint_mv_o)));
endmodule

// File: tb/vid_pgood_mon_bench.sv
`timescale 1ns/1ps
module vid_pgood_mon_bench;
  localparam int MV_W = 13;
  localparam int BLANK = 4;

  logic clk = 0, rst_n = 0, sv = 0;
  logic [4:0] vid = 0;
  logic [MV_W-1:0] vcore = 0;
  logic [3*MV_W-1:0] lin = 0;
  logic [MV_W-1:0] sp_o;
  logic pg_o, ov_o;

  always #2 clk = ~clk;

  vid_pgood_mon u_vid_pgood_mon (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv), .vid_i(vid),
    .vcore_mv_i(vcore), .lin_mv_i(lin), .setpoint_mv_o(sp_o),
    .pgood_o(pg_o), .ov_o(ov_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int tgt[3] = '{1500, 1500, 1800};
  int m_vid = 0, m_blank = BLANK, m_core = 0;
  int m_lin[3] = '{0, 0, 0};
  int e_sp, e_pg, e_ov;
  string e_tag;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dec(int v);
    if (v[4]) return 2000 + 100 * (15 - v[3:0]);
    return 1300 + 50 * (15 - v[3:0]);
  endfunction

  task automatic model(string tag, int v, int vc, int l0, int l1, int l2);
    int ls[3];
    bit change, blanked, all_lin;
    ls = '{l0, l1, l2};
    e_sp = dec(v);
    change = (v != m_vid);
    blanked = change || (m_blank != 0);
    if (change) m_core = 0;
    else if (m_core == 1 && (vc*100 < e_sp*92 || vc*100 > e_sp*110)) m_core = 0;
    else if (m_core == 0 && vc*100 >= e_sp*94 && vc*100 <= e_sp*108) m_core = 1;
    all_lin = 1;
    for (int i = 0; i < 3; i++) begin
      if (m_lin[i] == 1 && ls[i]*100 < tgt[i]*75) m_lin[i] = 0;
      else if (m_lin[i] == 0 && ls[i]*100 >= tgt[i]*82) m_lin[i] = 1;
      if (m_lin[i] == 0) all_lin = 0;
    end
    e_ov = (vc*100 > e_sp*115) ? 1 : 0;
    if (v == 31) begin e_pg = 1; e_tag = "R7"; end
    else if (blanked) begin e_pg = 0; e_tag = "R8"; end
    else begin e_pg = (m_core == 1 && all_lin) ? 1 : 0; e_tag = tag; end
    m_blank = change ? BLANK : (m_blank > 0 ? m_blank - 1 : 0);
    m_vid = v;
  endtask

  task automatic smp(string tag, int v, int vc, int l0, int l1, int l2);
    @(negedge clk);
    vid = 5'(v); vcore = MV_W'(vc);
    lin = {MV_W'(l2), MV_W'(l1), MV_W'(l0)};
    sv = 1;
    model(tag, v, vc, l0, l1, l2);
    @(negedge clk);
    sv = 0;
    chk(v[4] ? "R2" : "R1", "setpoint", int'(sp_o), e_sp);
    chk("R5", "ov", int'(ov_o), e_ov);
    chk(e_tag, "pgood", int'(pg_o), e_pg);
  endtask

  task automatic nom(string tag, int v, int vc);
    smp(tag, v, vc, 1500, 1500, 1800);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pl[14] = '{100, 100, 100, 100, 100, 93, 91, 93, 95, 109, 111, 109, 107, 116};
    int lp[6]  = '{100, 80, 74, 80, 83, 100};
    int sp;
    repeat (3) @(negedge clk);
    chk("R9", "rst pgood", int'(pg_o), 0);
    chk("R9", "rst ov", int'(ov_o), 0);
    chk("R9", "rst setpoint", int'(sp_o), 0);
    rst_n = 1;
    // reset blanking with unchanged code 00000 (2050 mV)
    for (int i = 0; i < BLANK; i++) begin
      nom("R9", 0, 2050);
      chk("R9", "post-reset blank", int'(pg_o), 0);
    end
    nom("R11", 0, 2050);
    chk("R11", "good after blank", int'(pg_o), 1);
    // exact boundaries at 2050 mV: 92% = 1886, 115% = 2357.5
    nom("R3", 0, 1886);
    chk("R3", "lo boundary holds", int'(pg_o), 1);
    nom("R3", 0, 1885);
    chk("R3", "lo trip", int'(pg_o), 0);
    nom("R3", 0, 1900);
    chk("R3", "band stays bad", int'(pg_o), 0);
    nom("R3", 0, 1927);
    chk("R3", "lo release", int'(pg_o), 1);
    nom("R5", 0, 2357);
    chk("R5", "ov boundary", int'(ov_o), 0);
    nom("R5", 0, 2358);
    chk("R5", "ov over", int'(ov_o), 1);
    // hold between strobes
    @(negedge clk);
    vid = 5'd17; vcore = 13'd100; lin = '0;
    repeat (3) @(negedge clk);
    chk("R10", "hold setpoint", int'(sp_o), 2050);
    chk("R10", "hold ov", int'(ov_o), 1);
    chk("R10", "hold pgood", int'(pg_o), 0);
    // sweep every code through window and hysteresis bands
    for (int c = 0; c < 32; c++) begin
      sp = dec(c);
      nom("R4", c, sp / 2);
      for (int k = 0; k < 14; k++)
        nom(k < 9 ? "R3" : "R4", c, sp * pl[k] / 100);
    end
    // linear undervoltage hysteresis per rail
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 6; k++) begin
        int ls[3];
        ls = '{1500, 1500, 1800};
        ls[r] = tgt[r] * lp[k] / 100;
        smp("R6", 10, dec(10), ls[0], ls[1], ls[2]);
      end
    end
    // blanking after a change, then force-good code over a bad rail
    nom("R8", 3, dec(3));
    for (int i = 0; i < BLANK; i++) begin
      nom("R8", 3, dec(3));
      chk("R8", "blank window", int'(pg_o), 0);
    end
    nom("R11", 3, dec(3));
    chk("R11", "good after change", int'(pg_o), 1);
    smp("R7", 31, 0, 0, 0, 0);
    chk("R7", "force good", int'(pg_o), 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule